// File: doc/BRIEF.md
# Dual Peripheral Port Direct I/O

This block serves two 7-bit peripheral ports. Each port pin is modelled as a separate input, output value and output enable, which stand in for a tri-state pad. For each port, the host reaches a data register and a per-bit direction register over a simple register bus. A mode register sets, for each port, who owns the pins. In automatic mode an external polling engine owns them through a dedicated output bus. In direct mode the host's data and direction registers own them. Every pin input passes through a two-flop synchroniser. The synchronised levels feed the host readback, the polling engine's input bus and the interrupt logic.

Each port has its own interrupt output. The interrupt fires on a falling edge of a trigger chosen per port. The trigger is either port bit 6 (the TH line) or a shared external latch strobe, and that strobe is also synchronised. The interrupt is produced only while the port is in direct mode. The register bus has no handshake. A write is taken on any clock edge where the write strobe is high, and read data follows the address combinationally.

Top module: `dual_port_dio`

## Requirements
- R1: After reset, the direction, mode and trigger-select registers read zero, both interrupts are low, and both ports follow the automatic bus.
- R2: Six byte offsets are decoded: port A data 0x75, port B data 0x77, port A direction 0x79, port B direction 0x7B, mode 0x7D and trigger select 0x7F. Data and direction registers store all 7 bits. Mode and trigger select store bits 1:0 and read zero above. A write to any other offset changes nothing, and a read of any other offset returns zero.
- R3: In direct mode a port drives each pin's enable from its direction bit (1 = output) and each pin's value from its data register bit.
- R4: Reading a data register returns the register bit where the direction bit is 1. Where the direction bit is 0 it returns the pin level, and a pin change becomes visible after the second rising clock edge.
- R5: Mode bit 0 selects port A and bit 1 selects port B. A value of 1 means direct and 0 means automatic. In automatic mode the pin value and enable follow the automatic bus, and host data and direction writes are held without reaching the pins until direct mode is chosen.
- R6: In both modes, each port's automatic input bus carries the synchronised pin levels, two clock edges behind the pins.
- R7: Trigger-select bit 0 applies to port A and bit 1 to port B. A value of 1 selects the external latch strobe and 0 selects port bit 6. A port that does not select a source is not triggered by that source.
- R8: A falling edge of the selected trigger gives a one-cycle interrupt pulse, high after the third rising edge following the change. A rising edge gives no pulse, and a port in automatic mode gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data for bus_addr |
| ext_latch | input | 1 | External latch strobe, asynchronous |
| pa_pin_i | input | 7 | Port A pin levels |
| pa_pin_o | output | 7 | Port A pin drive values |
| pa_pin_oe | output | 7 | Port A pin drive enables |
| pb_pin_i | input | 7 | Port B pin levels |
| pb_pin_o | output | 7 | Port B pin drive values |
| pb_pin_oe | output | 7 | Port B pin drive enables |
| pa_auto_out | input | 7 | Port A values from the polling engine |
| pa_auto_oe | input | 7 | Port A enables from the polling engine |
| pa_auto_in | output | 7 | Port A synchronised levels to the polling engine |
| pb_auto_out | input | 7 | Port B values from the polling engine |
| pb_auto_oe | input | 7 | Port B enables from the polling engine |
| pb_auto_in | output | 7 | Port B synchronised levels to the polling engine |
| irq_a | output | 1 | Port A interrupt pulse |
| irq_b | output | 1 | Port B interrupt pulse |

## Verification
A mode or direction bit stored wrongly shows on the pin enables in the same cycle as the write that caused it. A broken synchroniser stage shows on the readback and the automatic input bus one edge early or late. A stale edge-detect flop shows as a missing, doubled or spurious pulse. That pulse appears one cycle after the synchroniser delivers the edge, so the bench counts edges exactly from each pin change. It also checks the cycles after each change for pulses that must not occur.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int PORT_W   = 7;
  localparam int NPORT    = 2;
  localparam int ADDR_W   = 7;
  localparam int TRIG_BIT = 6;
  localparam int SYNC_N   = 2;

  localparam logic [ADDR_W-1:0] OFS_DATA0 = 7'h75;
  localparam logic [ADDR_W-1:0] OFS_DIR0  = 7'h79;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 7'h7D;
  localparam logic [ADDR_W-1:0] OFS_TSEL  = 7'h7F;

  function automatic logic [ADDR_W-1:0] data_ofs(input int k);
    return OFS_DATA0 + ADDR_W'(2 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] dir_ofs(input int k);
    return OFS_DIR0 + ADDR_W'(2 * k);
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [N-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= '0;
    else begin
      stage[0] <= d;
      for (int i = 1; i < N; i++) stage[i] <= stage[i-1];
    end
  end
  assign q = stage[N-1];

  // cycles since reset, saturating, so $past never reaches before reset
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  if (N == 2) begin : g_chk
    a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [PORT_W-1:0]             bus_wdata,
  output logic [PORT_W-1:0]             bus_rdata,
  input  logic [NPORT-1:0][PORT_W-1:0]  pin_s,
  output logic [NPORT-1:0][PORT_W-1:0]  data_q,
  output logic [NPORT-1:0][PORT_W-1:0]  dir_q,
  output logic [NPORT-1:0]              direct_q,
  output logic [NPORT-1:0]              tsel_q
);
  localparam int PAD_W = PORT_W - NPORT;

  for (genvar k = 0; k < NPORT; k++) begin : g_port_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[k] <= '0;
        dir_q[k]  <= '0;
      end else if (bus_we) begin
        if (bus_addr == data_ofs(k)) data_q[k] <= bus_wdata;
        if (bus_addr == dir_ofs(k))  dir_q[k]  <= bus_wdata;
      end
    end

    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == dir_ofs(k)) |=> (dir_q[k] == $past(bus_wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direct_q <= '0;
      tsel_q   <= '0;
    end else if (bus_we) begin
      if (bus_addr == OFS_MODE) direct_q <= bus_wdata[NPORT-1:0];
      if (bus_addr == OFS_TSEL) tsel_q   <= bus_wdata[NPORT-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NPORT; k++) begin
      if (bus_addr == data_ofs(k))
        bus_rdata = (dir_q[k] & data_q[k]) | (~dir_q[k] & pin_s[k]);
      if (bus_addr == dir_ofs(k))
        bus_rdata = dir_q[k];
    end
    if (bus_addr == OFS_MODE) bus_rdata = {{PAD_W{1'b0}}, direct_q};
    if (bus_addr == OFS_TSEL) bus_rdata = {{PAD_W{1'b0}}, tsel_q};
  end

  a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_MODE) |=> (direct_q == $past(bus_wdata[NPORT-1:0])));
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFS_MODE) |=> $stable(direct_q));
endmodule

// File: rtl/dio_port.sv
module dio_port
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] data,
  input  logic [PORT_W-1:0] dir,
  input  logic              direct,
  input  logic              tsel,
  input  logic              ext_s,
  input  logic [PORT_W-1:0] auto_out,
  input  logic [PORT_W-1:0] auto_oe,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_s,
  output logic              irq
);
  dio_sync #(.W(PORT_W), .N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  // pin ownership
  assign pin_o  = direct ? data : auto_out;
  assign pin_oe = direct ? dir  : auto_oe;

  // trigger source and falling-edge detect
  logic src, src_prev;
  assign src = tsel ? ext_s : pin_s[TRIG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prev <= 1'b0;
      irq      <= 1'b0;
    end else begin
      src_prev <= src;
      irq      <= direct & src_prev & ~src;
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r8_direct_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(direct));
endmodule

// File: rtl/dual_port_dio.sv
module dual_port_dio
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              ext_latch,
  input  logic [PORT_W-1:0] pa_pin_i,
  output logic [PORT_W-1:0] pa_pin_o,
  output logic [PORT_W-1:0] pa_pin_oe,
  input  logic [PORT_W-1:0] pb_pin_i,
  output logic [PORT_W-1:0] pb_pin_o,
  output logic [PORT_W-1:0] pb_pin_oe,
  input  logic [PORT_W-1:0] pa_auto_out,
  input  logic [PORT_W-1:0] pa_auto_oe,
  output logic [PORT_W-1:0] pa_auto_in,
  input  logic [PORT_W-1:0] pb_auto_out,
  input  logic [PORT_W-1:0] pb_auto_oe,
  output logic [PORT_W-1:0] pb_auto_in,
  output logic              irq_a,
  output logic              irq_b
);
  logic [NPORT-1:0][PORT_W-1:0] pin_i_w, pin_o_w, pin_oe_w, pin_s_w;
  logic [NPORT-1:0][PORT_W-1:0] aout_w, aoe_w, data_w, dir_w;
  logic [NPORT-1:0]             direct_w, tsel_w, irq_w;
  logic                         ext_s;

  assign pin_i_w = {pb_pin_i, pa_pin_i};
  assign aout_w  = {pb_auto_out, pa_auto_out};
  assign aoe_w   = {pb_auto_oe, pa_auto_oe};

  dio_sync #(.W(1), .N(SYNC_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_latch), .q(ext_s)
  );

  dio_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_s(pin_s_w), .data_q(data_w), .dir_q(dir_w),
    .direct_q(direct_w), .tsel_q(tsel_w)
  );

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    dio_port u_port (
      .clk(clk), .rst_n(rst_n),
      .pin_i(pin_i_w[k]), .data(data_w[k]), .dir(dir_w[k]),
      .direct(direct_w[k]), .tsel(tsel_w[k]), .ext_s(ext_s),
      .auto_out(aout_w[k]), .auto_oe(aoe_w[k]),
      .pin_o(pin_o_w[k]), .pin_oe(pin_oe_w[k]), .pin_s(pin_s_w[k]),
      .irq(irq_w[k])
    );
  end

  assign pa_pin_o   = pin_o_w[0];
  assign pa_pin_oe  = pin_oe_w[0];
  assign pb_pin_o   = pin_o_w[1];
  assign pb_pin_oe  = pin_oe_w[1];
  assign pa_auto_in = pin_s_w[0];
  assign pb_auto_in = pin_s_w[1];
  assign irq_a      = irq_w[0];
  assign irq_b      = irq_w[1];

  a_r5_auto_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) && $stable(pa_auto_oe) && !irq_a |-> $stable(pa_pin_oe));
endmodule

// File: tb/sim_dual_port_dio.sv
`timescale 1ns/1ps
module sim_dual_port_dio;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [6:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic ext_latch = 1'b1;
  logic [6:0] pa_pin_i = 7'h7F, pb_pin_i = 7'h7F;
  logic [6:0] pa_pin_o, pa_pin_oe, pb_pin_o, pb_pin_oe;
  logic [6:0] pa_auto_out = 7'h12, pa_auto_oe = 7'h33;
  logic [6:0] pb_auto_out = 7'h21, pb_auto_oe = 7'h0C;
  logic [6:0] pa_auto_in, pb_auto_in;
  logic irq_a, irq_b;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  dual_port_dio u0 (.*);

  // {write, addr, wdata, expected readback}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 7'h79, 7'h7F, 7'h7F},
    {1'b1, 7'h7B, 7'h7F, 7'h7F},
    {1'b1, 7'h75, 7'h55, 7'h55},
    {1'b1, 7'h77, 7'h2A, 7'h2A},
    {1'b1, 7'h7D, 7'h7F, 7'h03},
    {1'b1, 7'h7F, 7'h7E, 7'h02},
    {1'b1, 7'h7D, 7'h00, 7'h00},
    {1'b1, 7'h7F, 7'h00, 7'h00},
    {1'b1, 7'h74, 7'h33, 7'h00},
    {1'b0, 7'h75, 7'h00, 7'h55},
    {1'b1, 7'h76, 7'h11, 7'h00},
    {1'b0, 7'h77, 7'h00, 7'h2A}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [6:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [6:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!irq_a && !irq_b, tag, {irq_b, irq_a}, 0);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(7'h79, r); chk(r == 0, "R1 dirA", r, 0);
    rd(7'h7B, r); chk(r == 0, "R1 dirB", r, 0);
    rd(7'h7D, r); chk(r == 0, "R1 mode", r, 0);
    rd(7'h7F, r); chk(r == 0, "R1 tsel", r, 0);
    chk(!irq_a && !irq_b, "R1 irq", {irq_b, irq_a}, 0);
    chk(pa_pin_oe == 7'h33 && pa_pin_o == 7'h12, "R1 auto A", pa_pin_oe, 7'h33);
    rd(7'h75, r); chk(r == 7'h7F, "R4 input read", r, 7'h7F);

    // R2 register map walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:14], VEC[i][13:7]);
      rd(VEC[i][20:14], r);
      chk(r == VEC[i][6:0], "R2 map", r, VEC[i][6:0]);
    end

    // R5 held writes in automatic mode
    chk(pa_pin_oe == 7'h33 && pa_pin_o == 7'h12, "R5 held", pa_pin_oe, 7'h33);
    wr(7'h7D, 7'h01);
    chk(pa_pin_oe == 7'h7F, "R3 oe", pa_pin_oe, 7'h7F);
    chk(pa_pin_o == 7'h55, "R3 value", pa_pin_o, 7'h55);
    chk(pb_pin_oe == 7'h0C && pb_pin_o == 7'h21, "R5 B auto", pb_pin_oe, 7'h0C);

    // R4 mixed direction and sync delay
    wr(7'h79, 7'h0F);
    chk(pa_pin_oe == 7'h0F, "R3 oe mixed", pa_pin_oe, 7'h0F);
    pa_pin_i = 7'h4A;
    @(negedge clk); rd(7'h75, r); chk(r == 7'h75, "R4 one edge", r, 7'h75);
    @(negedge clk); rd(7'h75, r); chk(r == 7'h45, "R4 two edges", r, 7'h45);
    chk(pa_auto_in == 7'h4A, "R6 auto in", pa_auto_in, 7'h4A);
    chk(!irq_a, "R8 no irq", irq_a, 0);

    // R8 falling edge of bit 6 on port A (direct)
    pa_pin_i = 7'h0A;
    @(negedge clk); @(negedge clk);
    chk(!irq_a, "R8 early", irq_a, 0);
    @(negedge clk); chk(irq_a, "R8 pulse", irq_a, 1);
    @(negedge clk); chk(!irq_a, "R8 one cycle", irq_a, 0);
    pa_pin_i = 7'h4A;
    quiet(5, "R8 rising");

    // R8 port B in automatic mode
    pb_pin_i = 7'h3F;
    quiet(5, "R8 auto B");
    pb_pin_i = 7'h7F;
    quiet(4, "R8 auto B rise");

    // R7 external latch on port B
    wr(7'h7F, 7'h02);
    wr(7'h7D, 7'h03);
    quiet(3, "R7 settle");
    pb_pin_i = 7'h3F;
    quiet(5, "R7 bit6 ignored");
    pb_pin_i = 7'h7F;
    quiet(4, "R7 restore");
    ext_latch = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!irq_b, "R7 early", irq_b, 0);
    @(negedge clk);
    chk(irq_b, "R7 latch pulse", irq_b, 1);
    chk(!irq_a, "R7 A unaffected", irq_a, 0);
    @(negedge clk); chk(!irq_b, "R7 one cycle", irq_b, 0);
    ext_latch = 1'b1;
    quiet(4, "R7 latch rise");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule